// File: doc/BRIEF.md
# Next Program Counter Unit

This block holds the program counter of a small 8-bit controller core with a 16-bit code address space and works out the address of the next instruction. Each cycle the core presents the length of the instruction now executing, a target-mode code, a taken flag and the operand fields that the decoder extracted. The unit combines them into a next address, shown combinationally on `next_pc`. That address is loaded into the counter on the clock edge where the advance strobe is high.

Five modes are supported. Plain fall-through steps past the current instruction. A relative branch adds a signed byte to the fall-through address. An in-page branch keeps the 2 KB page of the fall-through address and replaces the low eleven bits. A long branch loads a full 16-bit address. An indexed target adds the unsigned accumulator to a base, which is either the data pointer or the fall-through address. All of the arithmetic wraps modulo 65536. The condition of a branch is evaluated outside this block, and only the relative mode consults the taken flag.

Top module: `pc_branch_unit`

## Requirements
- R1: While reset is asserted and right after it is released, `pc_q` reads 0000h.
- R2: On an edge where `advance` is 0, `pc_q` keeps its value whatever the mode and operand inputs are.
- R3: With `kind` = 0 (fall-through), the value loaded is `pc_q + ins_len`, where `ins_len` is the byte count (1, 2 or 3).
- R4: With `kind` = 1 (relative) and `taken` = 1, the value loaded is `pc_q + ins_len` plus `rel_off` read as two's complement, which gives a reach of -128 to +127 from the following instruction.
- R5: With `kind` = 1 and `taken` = 0, the value loaded is `pc_q + ins_len`.
- R6: With `kind` = 2 (in-page), the value loaded keeps bits 15:11 of `pc_q + ins_len` and takes bits 10:0 from `page_addr`. When the fall-through address crosses into a new page, the new page is the one used.
- R7: With `kind` = 3 (long), the value loaded is `long_addr`.
- R8: With `kind` = 4 (indexed), the value loaded is base + zero-extended `acc`. The base is `dptr` when `idx_use_dptr` = 1 and `pc_q + ins_len` when `idx_use_dptr` = 0.
- R9: Every sum wraps modulo 2^16 and no overflow is reported.
- R10: The `kind` codes 5, 6 and 7 behave exactly like fall-through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| advance | input | 1 | Loads `next_pc` into the counter on this edge |
| ins_len | input | 2 | Byte length of the current instruction |
| kind | input | 3 | Target mode: 0 fall-through, 1 relative, 2 in-page, 3 long, 4 indexed |
| taken | input | 1 | Condition result for relative mode |
| rel_off | input | 8 | Signed relative displacement |
| page_addr | input | 11 | In-page target field |
| long_addr | input | 16 | Full target address |
| idx_use_dptr | input | 1 | Indexed base select: 1 data pointer, 0 fall-through address |
| dptr | input | 16 | Data pointer value |
| acc | input | 8 | Accumulator value, unsigned |
| next_pc | output | 16 | Combinational next address |
| pc_q | output | 16 | Registered program counter |

## Verification
An error in the counter, such as a missed load or a load on a hold cycle, is visible on `pc_q` one edge after the strobe. Every later address then inherits the error, so a single slip shows up across the rest of the run. Sign-extension and page-splice faults appear only with particular operands. For that reason the stimulus drives the most negative and most positive displacements, a page crossing, and sums that pass FFFFh, and compares each loaded address at the edge that follows the stimulus.

// File: rtl/pc_unit_pkg.sv
package pc_unit_pkg;
  typedef enum logic [2:0] {
    BR_SEQ   = 3'd0,
    BR_REL   = 3'd1,
    BR_PAGE  = 3'd2,
    BR_LONG  = 3'd3,
    BR_INDEX = 3'd4
  } br_kind_e;
endpackage

// File: rtl/pc_fall_adder.sv
module pc_fall_adder #(
  parameter int AW   = 16,
  parameter int LENW = 2
) (
  input  logic [AW-1:0]   pc,
  input  logic [LENW-1:0] len,
  output logic [AW-1:0]   fall
);
  localparam int PADW = AW - LENW;

  always_comb begin
    fall = pc + {{PADW{1'b0}}, len};
  end
endmodule

// File: rtl/pc_target_sel.sv
module pc_target_sel
  import pc_unit_pkg::*;
#(
  parameter int AW    = 16,
  parameter int OFFW  = 8,
  parameter int PAGEW = 11,
  parameter int IDXW  = 8
) (
  input  logic [AW-1:0]    fall,
  input  logic [2:0]       kind,
  input  logic             taken,
  input  logic [OFFW-1:0]  rel_off,
  input  logic [PAGEW-1:0] page_addr,
  input  logic [AW-1:0]    long_addr,
  input  logic             idx_use_dptr,
  input  logic [AW-1:0]    dptr,
  input  logic [IDXW-1:0]  acc,
  output logic [AW-1:0]    target
);
  localparam int SEXW = AW - OFFW;
  localparam int ZEXW = AW - IDXW;

  logic [AW-1:0] rel_tgt;
  logic [AW-1:0] page_tgt;
  logic [AW-1:0] idx_base;
  logic [AW-1:0] idx_tgt;

  always_comb begin
    rel_tgt  = fall + {{SEXW{rel_off[OFFW-1]}}, rel_off};
    page_tgt = {fall[AW-1:PAGEW], page_addr};
    idx_base = idx_use_dptr ? dptr : fall;
    idx_tgt  = idx_base + {{ZEXW{1'b0}}, acc};
  end

  always_comb begin
    case (br_kind_e'(kind))
      BR_REL:   target = taken ? rel_tgt : fall;
      BR_PAGE:  target = page_tgt;
      BR_LONG:  target = long_addr;
      BR_INDEX: target = idx_tgt;
      default:  target = fall;
    endcase
  end
endmodule

// File: rtl/pc_branch_unit.sv
module pc_branch_unit
  import pc_unit_pkg::*;
#(
  parameter int AW    = 16,
  parameter int LENW  = 2,
  parameter int OFFW  = 8,
  parameter int PAGEW = 11,
  parameter int IDXW  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic [LENW-1:0]  ins_len,
  input  logic [2:0]       kind,
  input  logic             taken,
  input  logic [OFFW-1:0]  rel_off,
  input  logic [PAGEW-1:0] page_addr,
  input  logic [AW-1:0]    long_addr,
  input  logic             idx_use_dptr,
  input  logic [AW-1:0]    dptr,
  input  logic [IDXW-1:0]  acc,
  output logic [AW-1:0]    next_pc,
  output logic [AW-1:0]    pc_q
);
  localparam int LPADW = AW - LENW;

  logic [AW-1:0] fall;
  logic [AW-1:0] pc_d;

  pc_fall_adder #(.AW(AW), .LENW(LENW)) u_fall (
    .pc   (pc_q),
    .len  (ins_len),
    .fall (fall)
  );

  pc_target_sel #(.AW(AW), .OFFW(OFFW), .PAGEW(PAGEW), .IDXW(IDXW)) u_sel (
    .fall         (fall),
    .kind         (kind),
    .taken        (taken),
    .rel_off      (rel_off),
    .page_addr    (page_addr),
    .long_addr    (long_addr),
    .idx_use_dptr (idx_use_dptr),
    .dptr         (dptr),
    .acc          (acc),
    .target       (next_pc)
  );

  always_comb begin
    pc_d = advance ? next_pc : pc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  // R2: counter holds when not advancing
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(pc_q));
  // R3: loaded value is the address presented before the edge
  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> pc_q == $past(next_pc));
  assert_seq_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    kind == 3'd0 |-> (next_pc - pc_q) == {{LPADW{1'b0}}, ins_len});
  assert_not_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == 3'd1 && !taken) |-> (next_pc - pc_q) == {{LPADW{1'b0}}, ins_len});
  assert_fwd_reach_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == 3'd1 && taken && !rel_off[OFFW-1]) |-> (next_pc - fall) < AW'(128));
  assert_page_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    kind == 3'd2 |-> (next_pc[AW-1:PAGEW] == fall[AW-1:PAGEW]
                      && next_pc[PAGEW-1:0] == page_addr));
  assert_long_R7: assert property (@(posedge clk) disable iff (!rst_n)
    kind == 3'd3 |-> next_pc == long_addr);
  assert_spare_R10: assert property (@(posedge clk) disable iff (!rst_n)
    kind > 3'd4 |-> next_pc == fall);
endmodule

// File: tb/pc_branch_unit_tb.sv
`timescale 1ns/1ps
module pc_branch_unit_tb;
  typedef struct {
    logic [15:0] pc;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        advance = 1'b0;
  logic [1:0]  ins_len = '0;
  logic [2:0]  kind = '0;
  logic        taken = 1'b0;
  logic [7:0]  rel_off = '0;
  logic [10:0] page_addr = '0;
  logic [15:0] long_addr = '0;
  logic        idx_use_dptr = 1'b0;
  logic [15:0] dptr = '0;
  logic [7:0]  acc = '0;
  logic [15:0] next_pc;
  logic [15:0] pc_q;

  int total = 0;
  int bad = 0;
  exp_t sb[$];
  logic [15:0] model_pc = '0;

  always #2.5 clk = ~clk;

  pc_branch_unit u_dut (
    .clk(clk), .rst_n(rst_n), .advance(advance), .ins_len(ins_len),
    .kind(kind), .taken(taken), .rel_off(rel_off), .page_addr(page_addr),
    .long_addr(long_addr), .idx_use_dptr(idx_use_dptr), .dptr(dptr),
    .acc(acc), .next_pc(next_pc), .pc_q(pc_q)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: pc_q=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: apply one step and push the expected counter value
  task automatic step(input logic adv, input logic [2:0] k, input logic [1:0] len,
                      input logic tk, input logic [7:0] off, input logic [10:0] pg,
                      input logic [15:0] la, input logic ud, input logic [15:0] dp,
                      input logic [7:0] a, input string req);
    logic [15:0] f;
    logic [15:0] e;
    exp_t it;
    @(negedge clk);
    advance = adv; kind = k; ins_len = len; taken = tk; rel_off = off;
    page_addr = pg; long_addr = la; idx_use_dptr = ud; dptr = dp; acc = a;
    f = 16'(model_pc + 16'(len));
    case (k)
      3'd1: e = tk ? 16'(f + 16'(signed'(off))) : f;
      3'd2: e = {f[15:11], pg};
      3'd3: e = la;
      3'd4: e = 16'((ud ? dp : f) + {8'h00, a});
      default: e = f;
    endcase
    if (adv) model_pc = e;
    it.pc = model_pc;
    it.req = req;
    sb.push_back(it);
  endtask

  // monitor: compare after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t it;
        it = sb.pop_front();
        check(pc_q, it.pc, it.req);
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    bad++;
    $display("FAIL watchdog: pc_q=%h expected=done", pc_q);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check(pc_q, 16'h0000, "R1");
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk);
    #1 check(pc_q, 16'h0000, "R1");
    // R3 fall-through
    step(1, 3'd0, 2'd1, 0, 8'h00, 11'h0, 16'h0, 0, 16'h0, 8'h00, "R3");
    step(1, 3'd0, 2'd3, 0, 8'h00, 11'h0, 16'h0, 0, 16'h0, 8'h00, "R3");
    step(1, 3'd0, 2'd2, 0, 8'h00, 11'h0, 16'h0, 0, 16'h0, 8'h00, "R3");
    // R2 hold with a long target presented
    step(0, 3'd3, 2'd3, 1, 8'h00, 11'h0, 16'h1234, 0, 16'h0, 8'h00, "R2");
    step(0, 3'd1, 2'd2, 1, 8'h7F, 11'h0, 16'h0, 0, 16'h0, 8'h00, "R2");
    // R7 long
    step(1, 3'd3, 2'd3, 0, 8'h00, 11'h0, 16'h1234, 0, 16'h0, 8'h00, "R7");
    // R4 relative taken: +16, -128, +127
    step(1, 3'd1, 2'd2, 1, 8'h10, 11'h0, 16'h0, 0, 16'h0, 8'h00, "R4");
    step(1, 3'd1, 2'd2, 1, 8'h80, 11'h0, 16'h0, 0, 16'h0, 8'h00, "R4");
    step(1, 3'd1, 2'd2, 1, 8'h7F, 11'h0, 16'h0, 0, 16'h0, 8'h00, "R4");
    // R5 not taken
    step(1, 3'd1, 2'd2, 0, 8'h80, 11'h0, 16'h0, 0, 16'h0, 8'h00, "R5");
    // R6 in-page, then page crossing by the fall-through address
    step(1, 3'd2, 2'd2, 0, 8'h00, 11'h5AA, 16'h0, 0, 16'h0, 8'h00, "R6");
    step(1, 3'd3, 2'd3, 0, 8'h00, 11'h0, 16'h17FE, 0, 16'h0, 8'h00, "R7");
    step(1, 3'd2, 2'd2, 0, 8'h00, 11'h001, 16'h0, 0, 16'h0, 8'h00, "R6");
    // R8 indexed from data pointer and from following address
    step(1, 3'd4, 2'd1, 0, 8'h00, 11'h0, 16'h0, 1, 16'h2000, 8'hF0, "R8");
    step(1, 3'd4, 2'd1, 0, 8'h00, 11'h0, 16'h0, 0, 16'h9999, 8'h80, "R8");
    // R9 wrap cases
    step(1, 3'd3, 2'd3, 0, 8'h00, 11'h0, 16'hFFFF, 0, 16'h0, 8'h00, "R7");
    step(1, 3'd0, 2'd1, 0, 8'h00, 11'h0, 16'h0, 0, 16'h0, 8'h00, "R9");
    step(1, 3'd3, 2'd3, 0, 8'h00, 11'h0, 16'hFFF0, 0, 16'h0, 8'h00, "R7");
    step(1, 3'd1, 2'd2, 1, 8'h7F, 11'h0, 16'h0, 0, 16'h0, 8'h00, "R9");
    step(1, 3'd4, 2'd1, 0, 8'h00, 11'h0, 16'h0, 1, 16'hFFFF, 8'hFF, "R9");
    step(1, 3'd3, 2'd3, 0, 8'h00, 11'h0, 16'h0010, 0, 16'h0, 8'h00, "R7");
    step(1, 3'd1, 2'd2, 1, 8'h80, 11'h0, 16'h0, 0, 16'h0, 8'h00, "R9");
    // R10 spare codes act as fall-through
    step(1, 3'd5, 2'd2, 1, 8'h40, 11'h7FF, 16'hABCD, 1, 16'h5555, 8'h11, "R10");
    step(1, 3'd6, 2'd1, 1, 8'h40, 11'h7FF, 16'hABCD, 1, 16'h5555, 8'h11, "R10");
    step(1, 3'd7, 2'd3, 1, 8'h40, 11'h7FF, 16'hABCD, 1, 16'h5555, 8'h11, "R10");
    @(negedge clk) advance = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule